// File: doc/BRIEF.md
# FIFO-Buffered Synchronous Serial Controller

This block is a master-mode synchronous serial port controlled through a small 32-bit register port. Software writes words into a data register; each word is queued in an 8-entry transmit FIFO. A shift engine takes words from that FIFO one at a time. It clocks each word out on a serial data line, most significant bit first, and at the same time clocks a word in from the return line. The received word is trimmed to the programmed frame size and placed in an 8-entry receive FIFO. Software collects it by reading the same data register.

A loopback mode skips the serial pins and moves each queued word directly into the receive FIFO, one word per cycle. The transmit side never runs ahead of the receive side. When the receive FIFO is full, the engine waits, so no received word is ever lost. A status word and two FIFO-level interrupt flags are derived from the fill levels. The flags are masked and merged onto a single registered interrupt line. A fixed identification code can be read from the top of the register window.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset both FIFOs are empty. The status register (0x0C) reads 0x03, the raw interrupt register (0x18) reads 0x08, the masked register (0x1C) reads 0, `irq` is 0, `cs_n` is 1 and `sclk` is 0.
- R2: A read strobe at offset A presents that register on `reg_rdata` one clock later. Format (0x00) keeps 16 bits, mode (0x04) keeps 4 bits, prescale (0x10) keeps 8 bits and interrupt enable (0x14) keeps 4 bits, and each reads back what was written. Offset 0x20 always reads 0.
- R3: The word mask is 2^(N+1)-1, where N is format bits [3:0]. The mask is applied when a word enters the transmit FIFO and again when a word enters the receive FIFO.
- R4: Mode bit 1 enables the port. While it is 0, no word leaves the transmit FIFO, even with loopback selected.
- R5: Status bits are: bit0 transmit FIFO empty, bit1 transmit FIFO not full, bit2 receive FIFO not empty, bit3 receive FIFO full, bit4 busy. Busy is set while the transmit FIFO holds any word.
- R6: In the raw register, bit2 is set when the receive FIFO holds at least 4 words, and bit3 is set when the transmit FIFO holds at most 4 words. Offset 0x1C reads raw AND enable. `irq` is high one cycle after any enabled raw bit is set.
- R7: A word is transferred only while the transmit FIFO is non-empty and the receive FIFO is not full. A full receive FIFO stalls the transmit side, and words keep their order with none dropped.
- R8: Reading data (0x08) from an empty receive FIFO returns 0 and changes nothing. A data write to a full transmit FIFO is discarded.
- R9: With mode bit 0 (loopback) set, each word returns unchanged as the received word, one per cycle. `cs_n` stays 1 and `sclk` stays 0 throughout.
- R10: In serial mode (loopback clear), `sclk` idles low and has a period of 2*max(prescale,2) clocks. `mosi` carries the word MSB first and is stable while `sclk` is high. `miso` is sampled on each rising `sclk` edge, and `cs_n` is low for the whole frame.
- R11: Offsets 0xFE0 + 4*i (i = 0..7) read byte i of the `ID_CODE` parameter, where byte i is bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Masked interrupt, registered |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select, low during a frame |

## Verification
Register reads have a fixed latency of one clock. The bench therefore pushes each expected value into a scoreboard when it raises the read strobe, and the monitor compares the value on the falling edge after the next rising edge. Loopback moves a word on the cycle after it becomes eligible, and `irq` follows the FIFO levels with one cycle of delay. For that reason, the bench leaves a few idle cycles after each write before it reads status or samples `irq`. A serial frame lasts 2*max(prescale,2)*(N+1) clocks. Rather than predicting the cycle a frame ends, the bench waits for `cs_n` to return high. It measures the `sclk` period and collects the `mosi` bits on the falling clock edge after each rising `sclk`.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  localparam logic [11:0] OFF_FMT  = 12'h000;
  localparam logic [11:0] OFF_MODE = 12'h004;
  localparam logic [11:0] OFF_DATA = 12'h008;
  localparam logic [11:0] OFF_STAT = 12'h00C;
  localparam logic [11:0] OFF_PRE  = 12'h010;
  localparam logic [11:0] OFF_IEN  = 12'h014;
  localparam logic [11:0] OFF_RAW  = 12'h018;
  localparam logic [11:0] OFF_ACT  = 12'h01C;
  localparam logic [11:0] OFF_DMA  = 12'h020;
  localparam logic [6:0]  ID_PAGE  = 7'h7F;

  typedef enum logic {ENG_IDLE = 1'b0, ENG_SHIFT = 1'b1} eng_state_e;
endpackage

// File: rtl/ssp_fifo.sv
`timescale 1ns/1ps
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  pdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= pdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R8
  fifo_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full) |=> (count == FULL_CNT));
endmodule

// File: rtl/ssp_shift.sv
`timescale 1ns/1ps
module ssp_shift
  import ssp_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIV_W = 8,
  localparam int IW   = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W-1:0]     word,
  input  logic [IW-1:0]    last_idx,
  input  logic [DIV_W-1:0] half,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     rx_word,
  output logic             sclk,
  output logic             mosi
);
  eng_state_e       state;
  logic [DIV_W-1:0] div_cnt;
  logic [IW-1:0]    bit_idx;
  logic [W-1:0]     tx_sh, rx_sh;
  logic             sclk_q, mosi_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ENG_IDLE;
      div_cnt <= '0;
      bit_idx <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (start) begin
            state   <= ENG_SHIFT;
            tx_sh   <= word;
            rx_sh   <= '0;
            bit_idx <= last_idx;
            mosi_q  <= word[last_idx];
            div_cnt <= '0;
            sclk_q  <= 1'b0;
          end
        end
        ENG_SHIFT: begin
          if (div_cnt == half - 1'b1) begin
            div_cnt <= '0;
            sclk_q  <= ~sclk_q;
            if (!sclk_q) begin
              rx_sh <= {rx_sh[W-2:0], miso};
            end else if (bit_idx == '0) begin
              state  <= ENG_IDLE;
              done_q <= 1'b1;
            end else begin
              bit_idx <= bit_idx - 1'b1;
              mosi_q  <= tx_sh[bit_idx - 1'b1];
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign busy    = (state == ENG_SHIFT);
  assign done    = done_q;
  assign rx_word = rx_sh;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;

  // R10
  sclk_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_IDLE) |-> !sclk_q);

  // R10
  mosi_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_q));
endmodule

// File: rtl/ssp_ctrl.sv
`timescale 1ns/1ps
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter int          DEPTH   = 8,
  parameter int          PRE_W   = 8,
  parameter logic [63:0] ID_CODE = 64'h9C_41_07_00_5A_33_12_E4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  localparam int IW = $clog2(DATA_W);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] RX_THR = CW'(DEPTH / 2);
  localparam logic [CW-1:0] TX_THR = CW'(DEPTH / 2);
  localparam logic [IW-1:0] TOP_IDX = IW'(DATA_W - 1);

  logic [DATA_W-1:0] fmt_q;
  logic [3:0]        mode_q;
  logic [PRE_W-1:0]  pre_q;
  logic [3:0]        ien_q;

  logic [DATA_W-1:0] wmask, tx_head, rx_head, rx_in, eng_rx;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              port_on, loop_sel, eng_busy, eng_done, eng_start, lb_go;
  logic              wr_data, rd_data;
  logic [PRE_W-1:0]  half;
  logic [4:0]        stat;
  logic [3:0]        raw4;
  logic [31:0]       rd_val;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[31:DATA_W];

  assign wmask    = {DATA_W{1'b1}} >> (TOP_IDX - fmt_q[IW-1:0]);
  assign port_on  = mode_q[1];
  assign loop_sel = mode_q[0];
  assign wr_data  = reg_wr && (reg_addr == OFF_DATA);
  assign rd_data  = reg_rd && (reg_addr == OFF_DATA);
  assign half     = (pre_q < PRE_W'(2)) ? PRE_W'(2) : pre_q;

  assign lb_go     = port_on &&  loop_sel && !eng_busy && !eng_done && !tx_empty && !rx_full;
  assign eng_start = port_on && !loop_sel && !eng_busy && !eng_done && !tx_empty && !rx_full;
  assign rx_in     = (lb_go ? tx_head : eng_rx) & wmask;

  ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .push(wr_data), .pdata(reg_wdata[DATA_W-1:0] & wmask),
    .pop(lb_go || eng_start),
    .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .push(lb_go || eng_done), .pdata(rx_in),
    .pop(rd_data),
    .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  ssp_shift #(.W(DATA_W), .DIV_W(PRE_W)) u_eng (
    .clk(clk), .rst(rst),
    .start(eng_start), .word(tx_head), .last_idx(fmt_q[IW-1:0]),
    .half(half), .miso(miso),
    .busy(eng_busy), .done(eng_done), .rx_word(eng_rx),
    .sclk(sclk), .mosi(mosi)
  );

  assign stat = {!tx_empty, rx_full, !rx_empty, !tx_full, tx_empty};
  assign raw4 = {tx_cnt <= TX_THR, rx_cnt >= RX_THR, 2'b00};

  always_comb begin
    rd_val = '0;
    if (reg_addr[11:5] == ID_PAGE) begin
      rd_val = {24'h0, ID_CODE[{reg_addr[4:2], 3'b000} +: 8]};
    end else begin
      case (reg_addr)
        OFF_FMT:  rd_val = 32'(fmt_q);
        OFF_MODE: rd_val = 32'(mode_q);
        OFF_DATA: rd_val = rx_empty ? 32'h0 : 32'(rx_head);
        OFF_STAT: rd_val = 32'(stat);
        OFF_PRE:  rd_val = 32'(pre_q);
        OFF_IEN:  rd_val = 32'(ien_q);
        OFF_RAW:  rd_val = 32'(raw4);
        OFF_ACT:  rd_val = 32'(raw4 & ien_q);
        default:  rd_val = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q     <= '0;
      mode_q    <= '0;
      pre_q     <= '0;
      ien_q     <= '0;
      reg_rdata <= '0;
      irq       <= 1'b0;
      cs_n      <= 1'b1;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          OFF_FMT:  fmt_q  <= reg_wdata[DATA_W-1:0];
          OFF_MODE: mode_q <= reg_wdata[3:0];
          OFF_PRE:  pre_q  <= reg_wdata[PRE_W-1:0];
          OFF_IEN:  ien_q  <= reg_wdata[3:0];
          default:  ;
        endcase
      end
      if (reg_rd) reg_rdata <= rd_val;
      irq  <= |(raw4 & ien_q);
      cs_n <= !(eng_busy || eng_start);
    end
  end

  // R7
  rx_room_chk: assert property (@(posedge clk) disable iff (rst)
    eng_done |-> !rx_full);

  // R4
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !port_on |=> (tx_cnt >= $past(tx_cnt)));

  // R10
  cs_frame_chk: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> !cs_n);

  // R9
  lb_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (loop_sel && !eng_busy) |=> !eng_busy);
endmodule

// File: tb/ssp_ctrl_tb.sv
`timescale 1ns/1ps
module ssp_ctrl_tb;
  import ssp_pkg::*;

  localparam logic [63:0] TB_ID = 64'h6B_20_D1_8E_04_77_3F_A9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, sclk, mosi, miso, cs_n;
  logic        inv_miso = 1'b0;

  always #10 clk = ~clk;
  assign miso = inv_miso ? ~mosi : mosi;

  ssp_ctrl #(.ID_CODE(TB_ID)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;
  logic [31:0] e_v;
  string       t_v;

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", t, act, exp);
    end
  endtask

  // scoreboard monitor: read data is due one clock after the strobe
  always @(posedge clk) rd_pend <= reg_rd;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: unexpected read data actual 0x%08h expected none", reg_rdata);
      end else begin
        e_v = exp_q.pop_front();
        t_v = tag_q.pop_front();
        check(t_v, reg_rdata, e_v);
      end
    end
  end

  // serial pin monitor
  int          cyc = 0, last_rise = 0, per = 0, rises = 0;
  logic [15:0] bits = '0;
  logic        sclk_prev = 1'b0, cs_seen = 1'b0, lb_watch = 1'b0, lb_bad = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (sclk && !sclk_prev) begin
      bits = {bits[14:0], mosi};
      rises++;
      per = cyc - last_rise;
      last_rise = cyc;
    end
    sclk_prev = sclk;
    if (!cs_n) cs_seen = 1'b1;
    if (lb_watch && (!cs_n || sclk)) lb_bad = 1'b1;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_frame_end();
    int guard = 0;
    step(4);
    while (!cs_n && guard < 3000) begin
      step(1);
      guard++;
    end
    step(3);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 cs_n", {31'b0, cs_n}, 32'h1);
    check("R1 sclk", {31'b0, sclk}, 32'h0);
    rd(OFF_STAT, 32'h03, "R1 status");
    rd(OFF_RAW,  32'h08, "R1 raw");
    rd(OFF_ACT,  32'h00, "R1 masked");

    // R2 register readback
    wr(OFF_FMT, 32'h0001_FFFF);  rd(OFF_FMT,  32'h0000_FFFF, "R2 format");
    wr(OFF_PRE, 32'h0000_01FF);  rd(OFF_PRE,  32'h0000_00FF, "R2 prescale");
    wr(OFF_MODE, 32'h0000_001C); rd(OFF_MODE, 32'h0000_000C, "R2 mode");
    wr(OFF_IEN, 32'h0000_003F);  rd(OFF_IEN,  32'h0000_000F, "R2 enable");
    wr(OFF_IEN, 32'h0);
    wr(OFF_DMA, 32'h1);          rd(OFF_DMA,  32'h0, "R2 dma zero");
    wr(OFF_MODE, 32'h0);

    // R11 identification bytes
    for (int i = 0; i < 8; i++)
      rd(12'hFE0 + 12'(4 * i), {24'h0, TB_ID[8*i +: 8]}, "R11 id byte");

    // R3 word mask on both sides
    lb_watch = 1'b1;
    wr(OFF_FMT, 32'h7);  wr(OFF_DATA, 32'h1234);
    wr(OFF_FMT, 32'hF);  wr(OFF_DATA, 32'hABCD);
    wr(OFF_MODE, 32'h3); step(4);
    rd(OFF_DATA, 32'h0034, "R3 tx side mask");
    rd(OFF_DATA, 32'hABCD, "R3 full width");
    wr(OFF_MODE, 32'h0); wr(OFF_DATA, 32'hBEEF);
    wr(OFF_FMT, 32'h3);  wr(OFF_MODE, 32'h3); step(3);
    rd(OFF_DATA, 32'h000F, "R3 rx side mask");
    wr(OFF_MODE, 32'h0); wr(OFF_FMT, 32'hF);

    // R5 R6 thresholds, R4 port disabled
    for (int i = 1; i <= 4; i++) wr(OFF_DATA, 32'(i));
    step(2);
    rd(OFF_RAW,  32'h08, "R6 tx at threshold");
    rd(OFF_STAT, 32'h12, "R5 R4 four queued, held");
    wr(OFF_DATA, 32'h5); step(1);
    rd(OFF_RAW,  32'h00, "R6 tx above threshold");
    wr(OFF_IEN, 32'hC); step(2);
    check("R6 irq low", {31'b0, irq}, 32'h0);
    rd(OFF_ACT, 32'h00, "R6 masked none");
    wr(OFF_MODE, 32'h3); step(8);
    rd(OFF_RAW,  32'h0C, "R6 both raw");
    rd(OFF_ACT,  32'h0C, "R6 both masked");
    check("R6 irq high", {31'b0, irq}, 32'h1);
    rd(OFF_STAT, 32'h07, "R5 rx holds five");
    rd(OFF_DATA, 32'h1, "R9 word 1");
    rd(OFF_DATA, 32'h2, "R9 word 2");
    step(1);
    rd(OFF_RAW, 32'h08, "R6 rx below threshold");
    wr(OFF_IEN, 32'h4); step(2);
    check("R6 irq masked off", {31'b0, irq}, 32'h0);
    rd(OFF_ACT, 32'h00, "R6 masked rx only");
    rd(OFF_DATA, 32'h3, "R9 word 3");
    rd(OFF_DATA, 32'h4, "R9 word 4");
    rd(OFF_DATA, 32'h5, "R9 word 5");
    rd(OFF_DATA, 32'h0, "R8 empty read");
    rd(OFF_STAT, 32'h03, "R8 empty read no change");
    wr(OFF_IEN, 32'h0);

    // R7 R8 stall and discard
    wr(OFF_MODE, 32'h1);
    for (int i = 0; i < 8; i++) wr(OFF_DATA, 32'hA000 + 32'(i));
    wr(OFF_DATA, 32'h5555);
    step(5);
    rd(OFF_STAT, 32'h10, "R4 loopback while disabled");
    wr(OFF_MODE, 32'h3); step(12);
    rd(OFF_STAT, 32'h0F, "R5 rx full tx empty");
    for (int i = 0; i < 8; i++) wr(OFF_DATA, 32'hB000 + 32'(i));
    step(4);
    rd(OFF_STAT, 32'h1C, "R7 stalled both full");
    rd(OFF_DATA, 32'hA000, "R7 first word");
    step(3);
    rd(OFF_STAT, 32'h1E, "R7 one refilled");
    for (int i = 1; i < 8; i++) rd(OFF_DATA, 32'hA000 + 32'(i), "R7 order A");
    for (int i = 0; i < 8; i++) rd(OFF_DATA, 32'hB000 + 32'(i), "R7 order B");
    step(3);
    rd(OFF_DATA, 32'h0, "R8 full write discarded");
    rd(OFF_STAT, 32'h03, "R7 drained");
    step(2);
    lb_watch = 1'b0;
    check("R9 pins idle in loopback", {31'b0, lb_bad}, 32'h0);

    // R10 serial frames
    wr(OFF_MODE, 32'h0); wr(OFF_FMT, 32'h7); wr(OFF_PRE, 32'h3);
    wr(OFF_MODE, 32'h2);
    bits = '0; rises = 0; cs_seen = 1'b0;
    wr(OFF_DATA, 32'hA5);
    wait_frame_end();
    check("R10 msb first",  32'(bits[7:0]), 32'hA5);
    check("R10 edge count", 32'(rises), 32'd8);
    check("R10 period pre3", 32'(per), 32'd6);
    check("R10 select low", {31'b0, cs_seen}, 32'h1);
    check("R10 select idle", {31'b0, cs_n}, 32'h1);
    rd(OFF_DATA, 32'hA5, "R10 received echo");

    inv_miso = 1'b1;
    wr(OFF_PRE, 32'h0);
    bits = '0; rises = 0;
    wr(OFF_DATA, 32'h3C);
    wait_frame_end();
    check("R10 period min", 32'(per), 32'd4);
    rd(OFF_DATA, 32'hC3, "R10 received inverted");

    inv_miso = 1'b0;
    wr(OFF_FMT, 32'hB);
    bits = '0; rises = 0;
    wr(OFF_DATA, 32'hF9A5);
    wait_frame_end();
    check("R10 twelve bit frame", 32'(bits[11:0]), 32'h9A5);
    check("R10 twelve edges", 32'(rises), 32'd12);
    rd(OFF_DATA, 32'h9A5, "R10 R3 twelve bit echo");

    step(3);
    check("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule